// File: doc/BRIEF.md
# Second-Operand Shift and Rotate Unit

This unit builds the second operand of an integer ALU. It has two forms. In the register form it shifts a 32-bit source value left or right, arithmetically, or as a rotate. The shift amount comes from one of two places. One is a 5-bit field of the instruction word. The other is the least significant byte of a second register, which allows amounts from 0 to 255. In the immediate form it takes an 8-bit constant and rotates it right by twice a 4-bit rotate field. This gives a wide set of 32-bit constants from a short encoding. The first ALU operand does not pass through this unit.

Beside the 32-bit operand, the unit produces a shifter carry-out that the flag logic can use. The datapath is combinational. A parameter adds an output register, which is on by default. With that register, results appear one clock after the inputs are applied, and reset clears them. Register reads and the ALU itself sit outside the unit.

Top module: `operand_shifter`

## Requirements
- R1: With `use_imm`=1, `operand` equals `{24'b0, imm_val}` rotated right by `2*imm_rot` bit positions. The shift inputs are ignored in this form.
- R2: With `use_imm`=1, `carry_out` equals `carry_in` when `imm_rot`=0. For any other `imm_rot`, `carry_out` equals bit 31 of `operand`.
- R3: The shift kind is selected by `shift_kind`: 0 is logical left, 1 is logical right, 2 is arithmetic right, 3 is rotate right. A logical left shift by a field amount n of 1 to 31 gives `src_val << n` (multiply by 2^n), and `carry_out` is `src_val[32-n]`. A field amount of 0 with logical left passes `src_val` and `carry_in` unchanged.
- R4: With a field amount of 0, logical right and arithmetic right act as a shift by 32. Logical right gives 0. Arithmetic right copies `src_val[31]` into every bit. In both cases `carry_out` is `src_val[31]`.
- R5: With a field amount of 0, rotate right acts as a 33-bit rotate through carry. `operand` = `{carry_in, src_val[31:1]}` and `carry_out` = `src_val[0]`.
- R6: With `amt_in_reg`=1, only `amt_reg[7:0]` sets the amount. If that byte is 0, `operand` = `src_val` and `carry_out` = `carry_in` for every shift kind, whatever the value of `amt_reg[31:8]`.
- R7: With a register amount of exactly 32, logical left gives 0 with carry `src_val[0]`, and logical right gives 0 with carry `src_val[31]`.
- R8: With a register amount above 32, logical left and logical right both give `operand`=0 and `carry_out`=0.
- R9: With a register amount of 32 or more, arithmetic right fills all 32 bits of `operand` with `src_val[31]`, and `carry_out` is `src_val[31]`.
- R10: A rotate right with a nonzero register amount rotates by the amount modulo 32, and `carry_out` is bit 31 of the result. A nonzero multiple of 32 therefore returns `src_val` with carry `src_val[31]`.
- R11: With `OUT_REG`=1, each result appears on the outputs one clock edge after its inputs are applied. While `rst_n` is low, `operand` and `carry_out` are 0.
- R12: Right shifts by a field amount n of 1 to 31 give the shifted value. Logical right fills with zeros and arithmetic right fills with copies of bit 31. For both, and for a rotate by a nonzero amount n, `carry_out` is `src_val[n-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| use_imm | input | 1 | 1 selects the rotated-immediate form |
| imm_val | input | 8 | Immediate constant |
| imm_rot | input | 4 | Rotate field; rotation is twice this value |
| src_val | input | 32 | Register value to be shifted |
| shift_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| amt_in_reg | input | 1 | 1 takes the amount from `amt_reg[7:0]`, 0 from `amt_field` |
| amt_field | input | 5 | Instruction-field shift amount |
| amt_reg | input | 32 | Register supplying the amount in its low byte |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
In the default build every result appears at the clock edge that follows the falling edge on which the bench applied its inputs. The bench applies stimulus on falling edges and queues one expected item for each one. The monitor takes an item off the queue 2 ns after the next rising edge, so each result is compared exactly one edge after its stimulus. One nanosecond after each new stimulus, before the next rising edge, the bench also checks that the outputs still show the previous result. This confirms that the register adds no more than one cycle and no less.

// File: rtl/operand_shifter.sv
module operand_shifter #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        use_imm,
  input  logic [7:0]  imm_val,
  input  logic [3:0]  imm_rot,
  input  logic [31:0] src_val,
  input  logic [1:0]  shift_kind,
  input  logic        amt_in_reg,
  input  logic [4:0]  amt_field,
  input  logic [31:0] amt_reg,
  input  logic        carry_in,
  output logic [31:0] operand,
  output logic        carry_out
);

  localparam logic [1:0] K_LSL = 2'd0;
  localparam logic [1:0] K_LSR = 2'd1;
  localparam logic [1:0] K_ASR = 2'd2;

  logic unused_amt_hi;
  assign unused_amt_hi = ^amt_reg[31:8];

  logic [7:0] amt;
  logic       fld_zero, reg_zero;
  logic [8:0] eff;
  assign amt      = amt_in_reg ? amt_reg[7:0] : {3'b000, amt_field};
  assign fld_zero = !amt_in_reg && (amt_field == 5'd0);
  assign reg_zero = amt_in_reg && (amt_reg[7:0] == 8'd0);
  assign eff      = fld_zero ? 9'd32 : {1'b0, amt};

  logic [32:0]        lsl_v, lsr_v;
  logic signed [32:0] asr_v;
  logic [31:0]        ror_v, imm_v;
  assign lsl_v = {1'b0, src_val} << amt;
  assign lsr_v = {src_val, 1'b0} >> eff;
  assign asr_v = $signed({src_val, 1'b0}) >>> eff;
  assign ror_v = 32'({src_val, src_val} >> amt[4:0]);
  assign imm_v = 32'({24'd0, imm_val, 24'd0, imm_val} >> {imm_rot, 1'b0});

  logic [31:0] res;
  logic        cout;

  always_comb begin
    res  = src_val;
    cout = carry_in;
    if (use_imm) begin
      res  = imm_v;
      cout = (imm_rot == 4'd0) ? carry_in : imm_v[31];
    end else if (reg_zero || (fld_zero && shift_kind == K_LSL)) begin
      res  = src_val;
      cout = carry_in;
    end else begin
      case (shift_kind)
        K_LSL: begin res = lsl_v[31:0]; cout = lsl_v[32]; end
        K_LSR: begin res = lsr_v[32:1]; cout = lsr_v[0];  end
        K_ASR: begin res = asr_v[32:1]; cout = asr_v[0];  end
        default: begin
          if (fld_zero) begin
            res  = {carry_in, src_val[31:1]};
            cout = src_val[0];
          end else begin
            res  = ror_v;
            cout = ror_v[31];
          end
        end
      endcase
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          operand   <= '0;
          carry_out <= 1'b0;
        end else begin
          operand   <= res;
          carry_out <= cout;
        end
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign operand   = res;
      assign carry_out = cout;
    end
  endgenerate

endmodule

// File: rtl/operand_shifter_checks.sv
module operand_shifter_checks #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        use_imm,
  input logic [3:0]  imm_rot,
  input logic [31:0] src_val,
  input logic [1:0]  shift_kind,
  input logic        amt_in_reg,
  input logic [31:0] amt_reg,
  input logic        carry_in,
  input logic [31:0] operand,
  input logic        carry_out
);
  generate
    if (OUT_REG) begin : g_chk
      p_imm_carry_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (use_imm && imm_rot == 4'd0) |=> (carry_out == $past(carry_in)));

      p_imm_carry_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (use_imm && imm_rot != 4'd0) |=> (carry_out == operand[31]));

      p_reg_zero_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_imm && amt_in_reg && amt_reg[7:0] == 8'd0)
          |=> (operand == $past(src_val) && carry_out == $past(carry_in)));

      p_big_logical_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_imm && amt_in_reg && amt_reg[7:0] > 8'd32 && !shift_kind[1])
          |=> (operand == 32'd0 && !carry_out));

      p_asr_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_imm && amt_in_reg && amt_reg[7:0] >= 8'd32 && shift_kind == 2'd2)
          |=> (operand == {32{$past(src_val[31])}} && carry_out == $past(src_val[31])));

      p_ror_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_imm && amt_in_reg && amt_reg[7:0] != 8'd0 && shift_kind == 2'd3)
          |=> (carry_out == operand[31]));
    end
  endgenerate
endmodule

bind operand_shifter operand_shifter_checks #(.OUT_REG(OUT_REG)) u_checks (
  .clk(clk), .rst_n(rst_n), .use_imm(use_imm), .imm_rot(imm_rot),
  .src_val(src_val), .shift_kind(shift_kind), .amt_in_reg(amt_in_reg),
  .amt_reg(amt_reg), .carry_in(carry_in), .operand(operand), .carry_out(carry_out)
);

// File: tb/test_operand_shifter.sv
module test_operand_shifter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic use_imm = 1'b0, amt_in_reg = 1'b0, carry_in = 1'b0;
  logic [7:0]  imm_val = '0;
  logic [3:0]  imm_rot = '0;
  logic [31:0] src_val = '0, amt_reg = '0;
  logic [1:0]  shift_kind = '0;
  logic [4:0]  amt_field = '0;
  logic [31:0] operand;
  logic        carry_out;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [31:0] op; logic c; string tag; } exp_t;
  exp_t q[$];
  logic [31:0] last_op = '0;
  logic        last_c = 1'b0;

  always #4 clk = ~clk;

  operand_shifter i_operand_shifter (
    .clk(clk), .rst_n(rst_n), .use_imm(use_imm), .imm_val(imm_val), .imm_rot(imm_rot),
    .src_val(src_val), .shift_kind(shift_kind), .amt_in_reg(amt_in_reg),
    .amt_field(amt_field), .amt_reg(amt_reg), .carry_in(carry_in),
    .operand(operand), .carry_out(carry_out)
  );

  function automatic exp_t model(input logic ui, input logic [7:0] iv, input logic [3:0] ir,
                                 input logic [31:0] s, input logic [1:0] k, input logic inr,
                                 input logic [4:0] f, input logic [31:0] ar, input logic ci);
    exp_t e;
    int n;
    e.op = '0; e.c = ci; e.tag = "";
    if (ui) begin
      n = 2 * int'(ir);
      for (int i = 0; i < 32; i++) e.op[i] = ({24'd0, iv} >> ((i + n) % 32)) & 1;
      e.c = (ir == 0) ? ci : e.op[31];
      return e;
    end
    n = inr ? int'(ar[7:0]) : int'(f);
    if (n == 0 && (inr || k == 2'd0)) begin e.op = s; e.c = ci; return e; end
    if (n == 0 && k == 2'd3) begin e.op = {ci, s[31:1]}; e.c = s[0]; return e; end
    if (n == 0) n = 32;
    case (k)
      2'd0: begin
        for (int i = 0; i < 32; i++) e.op[i] = (i - n >= 0) ? s[i - n] : 1'b0;
        e.c = (n <= 32) ? s[32 - n] : 1'b0;
      end
      2'd1: begin
        for (int i = 0; i < 32; i++) e.op[i] = (i + n <= 31) ? s[i + n] : 1'b0;
        e.c = (n <= 32) ? s[n - 1] : 1'b0;
      end
      2'd2: begin
        for (int i = 0; i < 32; i++) e.op[i] = (i + n <= 31) ? s[i + n] : s[31];
        e.c = (n <= 32) ? s[n - 1] : s[31];
      end
      default: begin
        for (int i = 0; i < 32; i++) e.op[i] = s[(i + n) % 32];
        e.c = s[(n + 31) % 32];
      end
    endcase
    return e;
  endfunction

  task automatic drive(input logic ui, input logic [7:0] iv, input logic [3:0] ir,
                       input logic [31:0] s, input logic [1:0] k, input logic inr,
                       input logic [4:0] f, input logic [31:0] ar, input logic ci, input string tag);
    exp_t e;
    @(negedge clk);
    use_imm = ui; imm_val = iv; imm_rot = ir; src_val = s; shift_kind = k;
    amt_in_reg = inr; amt_field = f; amt_reg = ar; carry_in = ci;
    e = model(ui, iv, ir, s, k, inr, f, ar, ci);
    e.tag = tag;
    q.push_back(e);
    #1;
    checks++;
    if (operand !== last_op || carry_out !== last_c) begin
      errors++;
      $display("FAIL R11 early change: got %h/%b expected %h/%b", operand, carry_out, last_op, last_c);
    end
    last_op = e.op; last_c = e.c;
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (operand !== e.op || carry_out !== e.c) begin
        errors++;
        $display("FAIL %s: got %h/%b expected %h/%b", e.tag, operand, carry_out, e.op, e.c);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (operand !== 32'd0 || carry_out !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset: got %h/%b expected 00000000/0", operand, carry_out);
    end
    rst_n = 1'b1;
    // R1 / R2 immediate form
    drive(1, 8'hFF, 4'd4, 32'h0, 2'd0, 0, 5'd0, 32'h0, 0, "R1");
    drive(1, 8'h3F, 4'd0, 32'hDEAD_BEEF, 2'd1, 1, 5'd9, 32'h5, 1, "R2");
    drive(1, 8'h01, 4'd1, 32'h0, 2'd0, 0, 5'd0, 32'h0, 1, "R2");
    drive(1, 8'h02, 4'd1, 32'h0, 2'd0, 0, 5'd0, 32'h0, 0, "R2");
    drive(1, 8'hA5, 4'd15, 32'h0, 2'd3, 0, 5'd3, 32'h0, 0, "R1");
    // R3 logical left by field
    drive(0, 8'h0, 4'd0, 32'd5, 2'd0, 0, 5'd3, 32'h0, 0, "R3");
    drive(0, 8'h0, 4'd0, 32'h1234_5678, 2'd0, 0, 5'd0, 32'h0, 1, "R3");
    drive(0, 8'h0, 4'd0, 32'h8000_0001, 2'd0, 0, 5'd1, 32'h0, 0, "R3");
    // R12 right shifts and rotate by field
    drive(0, 8'h0, 4'd0, 32'h0000_00F0, 2'd1, 0, 5'd4, 32'h0, 1, "R12");
    drive(0, 8'h0, 4'd0, 32'h8000_0008, 2'd2, 0, 5'd4, 32'h0, 0, "R12");
    drive(0, 8'h0, 4'd0, 32'h1234_5678, 2'd3, 0, 5'd8, 32'h0, 0, "R12");
    drive(0, 8'h0, 4'd0, 32'h0000_0001, 2'd3, 0, 5'd1, 32'h0, 0, "R12");
    // R4 field amount 0 as shift by 32
    drive(0, 8'h0, 4'd0, 32'h8000_0000, 2'd1, 0, 5'd0, 32'h0, 0, "R4");
    drive(0, 8'h0, 4'd0, 32'h8000_0000, 2'd2, 0, 5'd0, 32'h0, 0, "R4");
    drive(0, 8'h0, 4'd0, 32'h7FFF_FFFF, 2'd2, 0, 5'd0, 32'h0, 1, "R4");
    // R5 rotate through carry
    drive(0, 8'h0, 4'd0, 32'h0000_0003, 2'd3, 0, 5'd0, 32'h0, 1, "R5");
    drive(0, 8'h0, 4'd0, 32'h0000_0002, 2'd3, 0, 5'd0, 32'h0, 0, "R5");
    // R6 register amount zero, upper bits ignored
    drive(0, 8'h0, 4'd0, 32'hCAFE_F00D, 2'd2, 1, 5'd7, 32'h0, 0, "R6");
    drive(0, 8'h0, 4'd0, 32'hCAFE_F00D, 2'd0, 1, 5'd7, 32'h0000_0100, 1, "R6");
    drive(0, 8'h0, 4'd0, 32'hCAFE_F00D, 2'd3, 1, 5'd0, 32'hFFFF_FF00, 1, "R6");
    // R7 exactly 32
    drive(0, 8'h0, 4'd0, 32'h0000_0001, 2'd0, 1, 5'd0, 32'd32, 0, "R7");
    drive(0, 8'h0, 4'd0, 32'h8000_0000, 2'd1, 1, 5'd0, 32'd32, 0, "R7");
    // R8 above 32
    drive(0, 8'h0, 4'd0, 32'hFFFF_FFFF, 2'd0, 1, 5'd0, 32'd33, 1, "R8");
    drive(0, 8'h0, 4'd0, 32'hFFFF_FFFF, 2'd1, 1, 5'd0, 32'd200, 1, "R8");
    // R9 arithmetic right by 32 or more
    drive(0, 8'h0, 4'd0, 32'h8000_0000, 2'd2, 1, 5'd0, 32'd40, 0, "R9");
    drive(0, 8'h0, 4'd0, 32'h7FFF_FFFF, 2'd2, 1, 5'd0, 32'd255, 1, "R9");
    // R10 rotate by register amount
    drive(0, 8'h0, 4'd0, 32'h8000_0000, 2'd3, 1, 5'd0, 32'd32, 0, "R10");
    drive(0, 8'h0, 4'd0, 32'h0000_0010, 2'd3, 1, 5'd0, 32'd36, 1, "R10");
    drive(0, 8'h0, 4'd0, 32'h0000_0001, 2'd3, 1, 5'd0, 32'd65, 0, "R10");
    // register amount below 32 on the left and right shifts
    drive(0, 8'h0, 4'd0, 32'h0000_0003, 2'd0, 1, 5'd0, 32'd31, 0, "R12");
    drive(0, 8'h0, 4'd0, 32'hC000_0000, 2'd1, 1, 5'd0, 32'd31, 0, "R12");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule